// File: doc/BRIEF.md
# Pixel Word to Panel Bus Formatter

This block sits between a pixel FIFO and the data pins of a parallel LCD panel. It accepts 32-bit memory words through a valid/ready handshake and emits one pixel per clock on a 24-line panel bus. A word holds either two packed 16-bit RGB565 pixels or one 24-bit pixel in its low three bytes. The word-length code, the byte-valid mask, the panel bus width and a truncation flag together select how each word is unpacked.

Invalid combinations of these settings raise a format-error flag. While the flag is up, the block accepts no words and drives no pixels. A FIFO-clear input drops any word that is only partly issued, so the next stream begins on a clean word boundary.

Top module: `pixfmt_top`

## Requirements
- R1: After reset `pixValid` is 0, `pixOut` is 0 and `fmtError` is 0.
- R2: In packed mode (`wordLen`=0, `byteMask`=4'hF), each word gives two pixels. The pixel from bits 15:0 comes first and the pixel from bits 31:16 comes second. Each pixel appears on `pixOut[15:0]` (red 15:11, green 10:5, blue 4:0), and `pixOut[23:16]` is 0.
- R3: In packed mode, `inReady` stays low while the first halfword of the held word is being issued. A new word is taken only in the cycle that issues the second halfword, or when nothing is held.
- R4: In wide mode (`wordLen`=3, `byteMask`=4'h7) with `trunc18`=0 on a 24-bit bus (`busWidth`=3), `pixOut` equals word bits 23:0 (red 23:16, green 15:8, blue 7:0). Bits 31:24 have no effect.
- R5: In wide mode with `trunc18`=1, `pixOut` is {6'b0, word[21:16], word[13:8], word[5:0]}. This applies on bus widths 1 (16-bit), 2 (18-bit) and 3 (24-bit).
- R6: Wide mode on an 8-bit bus (`busWidth`=0) raises `fmtError`. In that state `inReady` is 0 and `pixValid` is 0.
- R7: Every other setting outside the valid modes also raises `fmtError` and blocks all transfers. This covers: `wordLen` 1 or 2; a mask that does not match the word length; packed mode on an 8-bit bus; wide mode on a 16- or 18-bit bus with `trunc18`=0.
- R8: While `fifoClear` is high, `inReady` is 0 and the held word is dropped. The next cycle shows `pixValid`=0, and the next word accepted starts at its low halfword.
- R9: A word accepted at a clock edge gives its first pixel on `pixOut` after the following edge. With input always valid, `pixValid` stays high on every cycle in both modes.
- R10: `fmtError` shows the configuration one clock later. It is registered and updates on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoClear | input | 1 | Drop held word, reset halfword selector |
| wordLen | input | 2 | Pixel size code: 0 = 16-bit, 3 = 24-bit in 32-bit word |
| byteMask | input | 4 | Valid input bytes: 4'hF packed, 4'h7 wide |
| busWidth | input | 2 | Panel bus: 0 = 8, 1 = 16, 2 = 18, 3 = 24 lines |
| trunc18 | input | 1 | Keep low six bits of each colour byte |
| inData | input | 32 | Word from the pixel FIFO |
| inValid | input | 1 | FIFO word available |
| inReady | output | 1 | Word taken when both valid and ready are high |
| pixOut | output | 24 | Panel data bus |
| pixValid | output | 1 | `pixOut` holds a pixel this cycle |
| fmtError | output | 1 | Configuration not supported |

## Verification
A wrong halfword selector shows up on `pixOut` on the very next cycle, as swapped or repeated halves. A stuck holding-valid state shows up within one cycle, either as a gap in `pixValid` or as `inReady` high while a lower half is still pending. The bench models each clock behaviourally and compares `pixOut`, `pixValid`, `fmtError` and `inReady` on every cycle. A fault therefore appears at the first pixel it disturbs, not at the end of a frame.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int CHAN_W = 8;
  localparam int TRUNC_W = 6;

  typedef struct packed {
    logic load;      // capture inData into holding register
    logic issue;     // emit one pixel this cycle
    logic upperSel;  // pixel comes from the upper halfword
    logic wide;      // one 24-bit pixel per word
    logic trunc;     // keep low six bits per colour
    logic clear;     // discard held word
  } fmtStrobe_t;
endpackage

// File: rtl/pixfmt_ctrl.sv
module pixfmt_ctrl
  import pixfmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoClear,
  input  logic [1:0] wordLen,
  input  logic [3:0] byteMask,
  input  logic [1:0] busWidth,
  input  logic       trunc18,
  input  logic       inValid,
  output logic       inReady,
  output logic       fmtError,
  output fmtStrobe_t strb
);
  localparam logic [1:0] LEN_PACKED = 2'd0;
  localparam logic [1:0] LEN_WIDE   = 2'd3;
  localparam logic [3:0] MASK_PACKED = 4'hF;
  localparam logic [3:0] MASK_WIDE   = 4'h7;
  localparam logic [1:0] BUS_8  = 2'd0;
  localparam logic [1:0] BUS_24 = 2'd3;

  logic full, halfSel;
  logic okPacked, okWide, cfgBad, issue, lastPix, accept;

  always_comb begin
    okPacked = (wordLen == LEN_PACKED) && (byteMask == MASK_PACKED) && (busWidth != BUS_8);
    okWide   = (wordLen == LEN_WIDE) && (byteMask == MASK_WIDE) && (busWidth != BUS_8)
               && ((busWidth == BUS_24) || trunc18);
    cfgBad   = !(okPacked || okWide);
    issue    = full && !cfgBad && !fifoClear;
    lastPix  = issue && (okWide || halfSel);
    inReady  = !cfgBad && !fifoClear && (!full || lastPix);
    accept   = inValid && inReady;
  end

  always_comb begin
    strb.load     = accept;
    strb.issue    = issue;
    strb.upperSel = halfSel;
    strb.wide     = okWide;
    strb.trunc    = trunc18;
    strb.clear    = fifoClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      full     <= 1'b0;
      halfSel  <= 1'b0;
      fmtError <= 1'b0;
    end else begin
      fmtError <= cfgBad;
      if (fifoClear) begin
        full    <= 1'b0;
        halfSel <= 1'b0;
      end else begin
        if (lastPix)    halfSel <= 1'b0;
        else if (issue) halfSel <= 1'b1;
        if (accept)       full <= 1'b1;
        else if (lastPix) full <= 1'b0;
      end
    end
  end

  // R2
  upper_follows_lower_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && !strb.upperSel && !strb.wide) |=> strb.upperSel);

  // R3
  hold_narrow_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.wide) |=> (!inReady || strb.wide));
endmodule

// File: rtl/pixfmt_dpath.sv
module pixfmt_dpath
  import pixfmt_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int BUS_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmtStrobe_t        strb,
  input  logic [DATA_W-1:0] inData,
  output logic [BUS_W-1:0]  pixOut,
  output logic              pixValid
);
  localparam int HW = DATA_W / 2;
  localparam int PIX_W = 3 * CHAN_W;

  logic [DATA_W-1:0] holdWord;
  logic [HW-1:0]     halfPix;
  logic [BUS_W-1:0]  nextPix;

  always_comb begin
    halfPix = strb.upperSel ? holdWord[DATA_W-1:HW] : holdWord[HW-1:0];
    if (!strb.wide)
      nextPix = BUS_W'(halfPix);
    else if (strb.trunc)
      nextPix = BUS_W'({holdWord[2*CHAN_W +: TRUNC_W],
                        holdWord[CHAN_W +: TRUNC_W],
                        holdWord[0 +: TRUNC_W]});
    else
      nextPix = BUS_W'(holdWord[PIX_W-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWord <= '0;
      pixOut   <= '0;
      pixValid <= 1'b0;
    end else begin
      if (strb.load) holdWord <= inData;
      pixValid <= strb.issue;
      pixOut   <= strb.issue ? nextPix : '0;
    end
  end

  // R2
  packed_high_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && !strb.wide) |=> (pixOut[BUS_W-1:HW] == '0));

  // R8
  clear_idles_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !pixValid);
endmodule

// File: rtl/pixfmt_top.sv
module pixfmt_top
  import pixfmt_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int BUS_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoClear,
  input  logic [1:0]        wordLen,
  input  logic [3:0]        byteMask,
  input  logic [1:0]        busWidth,
  input  logic              trunc18,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [BUS_W-1:0]  pixOut,
  output logic              pixValid,
  output logic              fmtError
);
  fmtStrobe_t strb;

  pixfmt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fifoClear(fifoClear), .wordLen(wordLen),
    .byteMask(byteMask), .busWidth(busWidth), .trunc18(trunc18),
    .inValid(inValid), .inReady(inReady), .fmtError(fmtError), .strb(strb)
  );

  pixfmt_dpath #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .pixOut(pixOut), .pixValid(pixValid)
  );

  // R6
  err_no_pixel_chk: assert property (@(posedge clk) disable iff (!rstN)
    fmtError |-> !pixValid);
endmodule

// File: tb/pixfmt_top_bench.sv
module pixfmt_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoClear = 1'b0;
  logic [1:0] wordLen = 2'd0;
  logic [3:0] byteMask = 4'hF;
  logic [1:0] busWidth = 2'd1;
  logic trunc18 = 1'b0;
  logic [31:0] inData = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic [23:0] pixOut;
  logic pixValid, fmtError;

  always #5 clk = ~clk;

  pixfmt_top u_pixfmt_top (
    .clk(clk), .rstN(rstN), .fifoClear(fifoClear), .wordLen(wordLen),
    .byteMask(byteMask), .busWidth(busWidth), .trunc18(trunc18),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .pixOut(pixOut), .pixValid(pixValid), .fmtError(fmtError)
  );

  int checks = 0, fails = 0, cycles = 0;
  string curReq = "R1";
  logic [31:0] words [0:63];
  int srcIdx = 0;

  // behavioural model state
  bit mFull = 0, mHalf = 0;
  logic [31:0] mWord = '0;
  logic expValid = 0, expErr = 0;
  logic [23:0] expPix = '0;

  function automatic bit cfgBad();
    bit okP, okW;
    okP = (wordLen == 0) && (byteMask == 4'hF) && (busWidth != 0);
    okW = (wordLen == 3) && (byteMask == 4'h7) && (busWidth != 0) && (busWidth == 3 || trunc18);
    return !(okP || okW);
  endfunction

  function automatic logic [23:0] shape(logic [31:0] w, bit hi);
    if (wordLen == 0) return {8'h00, (hi ? w[31:16] : w[15:0])};
    if (trunc18) return {6'b0, w[21:16], w[13:8], w[5:0]};
    return w[23:0];
  endfunction

  function automatic bit modelReady();
    bit last;
    last = mFull && !cfgBad() && !fifoClear && (wordLen == 3 || mHalf);
    return !cfgBad() && !fifoClear && (!mFull || last);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mFull = 0; mHalf = 0; mWord = '0; expValid = 0; expPix = '0; expErr = 0;
    end else begin
      bit bad, iss, last, rdy;
      bad  = cfgBad();
      iss  = mFull && !bad && !fifoClear;
      last = iss && (wordLen == 3 || mHalf);
      rdy  = modelReady();
      expErr   = bad;
      expValid = iss;
      expPix   = iss ? shape(mWord, mHalf) : '0;
      if (fifoClear) begin
        mFull = 0; mHalf = 0;
      end else begin
        if (last) mHalf = 0; else if (iss) mHalf = 1;
        if (inValid && rdy) begin mFull = 1; mWord = inData; srcIdx++; end
        else if (last) mFull = 0;
      end
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", curReq, what, act, exp, cycles);
    end
  endtask

  // one cycle: compare registered outputs, drive new inputs, compare ready
  task automatic step(bit v, bit clr);
    @(negedge clk);
    check("pixValid", 32'(pixValid), 32'(expValid));
    check("pixOut", 32'(pixOut), 32'(expPix));
    check("fmtError", 32'(fmtError), 32'(expErr));
    inValid = v;
    fifoClear = clr;
    inData = words[srcIdx % 64];
    #1;
    check("inReady", 32'(inReady), 32'(modelReady()));
  endtask

  task automatic setCfg(logic [1:0] wl, logic [3:0] m, logic [1:0] bw, bit t);
    @(negedge clk);
    inValid = 0;
    wordLen = wl; byteMask = m; busWidth = bw; trunc18 = t;
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) step(0, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++)
      words[i] = {8'(i * 37 + 5), 8'(i * 11 + 200), 8'(i * 73 + 1), 8'(i * 29 + 90)};
    repeat (3) @(negedge clk);
    // R1 reset state
    check("pixValid", 32'(pixValid), 32'd0);
    check("pixOut", 32'(pixOut), 32'd0);
    check("fmtError", 32'(fmtError), 32'd0);
    rstN = 1'b1;

    // R2 R3 R9 packed stream, continuous valid
    curReq = "R2";
    setCfg(2'd0, 4'hF, 2'd1, 0);
    for (int i = 0; i < 12; i++) step(1, 0);
    drain();
    // R3 packed stream with gaps
    curReq = "R3";
    for (int i = 0; i < 14; i++) step(i % 3 != 0, 0);
    drain();
    // R4 R9 wide mode on 24-bit bus
    curReq = "R4";
    setCfg(2'd3, 4'h7, 2'd3, 0);
    for (int i = 0; i < 10; i++) step(1, 0);
    drain();
    // R5 truncation on 18-bit, 16-bit and 24-bit buses
    curReq = "R5";
    setCfg(2'd3, 4'h7, 2'd2, 1);
    for (int i = 0; i < 6; i++) step(1, 0);
    drain();
    setCfg(2'd3, 4'h7, 2'd1, 1);
    for (int i = 0; i < 4; i++) step(1, 0);
    drain();
    setCfg(2'd3, 4'h7, 2'd3, 1);
    for (int i = 0; i < 4; i++) step(1, 0);
    drain();
    // R8 clear in the middle of a packed word
    curReq = "R8";
    setCfg(2'd0, 4'hF, 2'd2, 0);
    step(1, 0); step(0, 0); step(0, 1); step(0, 0);
    for (int i = 0; i < 6; i++) step(1, 0);
    step(1, 1);
    for (int i = 0; i < 4; i++) step(1, 0);
    drain();
    // R6 wide mode on 8-bit bus
    curReq = "R6";
    setCfg(2'd3, 4'h7, 2'd0, 0);
    for (int i = 0; i < 4; i++) step(1, 0);
    // R7 other invalid settings, R10 error timing
    curReq = "R7";
    setCfg(2'd1, 4'hF, 2'd3, 0);
    for (int i = 0; i < 3; i++) step(1, 0);
    setCfg(2'd0, 4'h7, 2'd3, 0);
    for (int i = 0; i < 3; i++) step(1, 0);
    setCfg(2'd0, 4'hF, 2'd0, 0);
    for (int i = 0; i < 3; i++) step(1, 0);
    setCfg(2'd3, 4'h7, 2'd1, 0);
    for (int i = 0; i < 3; i++) step(1, 0);
    setCfg(2'd3, 4'hF, 2'd3, 1);
    for (int i = 0; i < 3; i++) step(1, 0);
    curReq = "R10";
    setCfg(2'd3, 4'h7, 2'd3, 0);
    for (int i = 0; i < 6; i++) step(1, 0);
    curReq = "R9";
    setCfg(2'd0, 4'hF, 2'd3, 0);
    for (int i = 0; i < 10; i++) step(1, 0);
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule